// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a synchronous host and an asynchronous static RAM whose data bus can be 16 or 8 bits wide. The host makes one access at a time. It raises a request together with a direction flag, a byte address, write data, a two-bit lane mask and a width flag. The controller then drives the chip selects, the write strobe, the output enable, the two lane enables, the width-select line and the word address. Every phase is timed by a down-counter, and each count is worked out from a nanosecond parameter and the clock period.

The tri-state data bus is split into three parts: a drive value, a per-bit drive enable and a sampled input. In 8-bit mode the controller drives the least significant address bit on the top data pin. The width-select line is only changed while the memory is deselected. Before the change the controller waits out a recovery interval, and after it a setup interval, and both intervals are set by parameters. A read always ends with a bus turnaround phase, so the controller cannot drive the bus while the memory may still be driving it.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is held and just after it is released, the memory is deselected (cs1_no=1, cs2_o=0), we_no=1, oe_no=1, lb_no=ub_no=1, byte_no=1 (16-bit mode), ready_o=0 and dq_oe_o=0.
- R2: A write in an unchanged width mode raises ready_o 6 clock edges after the edge that accepts it, at the default timings with a 20 ns clock. we_no is low for exactly 3 cycles and oe_no stays high whenever we_no is low.
- R3: A read in an unchanged width mode raises ready_o 5 clock edges after the edge that accepts it. rdata_o holds the data sampled from dq_i at that edge, and the controller drives no lower-byte data pin during the read.
- R4: ready_o is high for exactly one cycle. A request still held at the edge that ends the ready cycle is not accepted.
- R5: In 16-bit mode the lane enables follow the lane mask (lb_no=!be_i[0], ub_no=!be_i[1]). A lane that is not enabled is not written, and it reads back as zero in rdata_o.
- R6: In 8-bit mode (byte_no=0) both lane enables are low for the whole access and addr_i[0] is driven on dq bit 15. Write data goes out on dq[7:0], and read data is returned as {8'h00, dq_i[7:0]}.
- R7: When byte_mode_i differs from the current mode, byte_no toggles only while the memory is deselected. The access starts 2*SETTLE cycles later than usual, where SETTLE is T_MODE_NS rounded up to whole clock cycles.
- R8: The controller never drives dq[7:0] while oe_no is low. After a read, the memory stays deselected with oe_no high for at least the cycle that follows the ready cycle.
- R9: mem_addr_o (addr_i[ADDR_W:1]) stays stable for as long as the chip selects are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, held until ready_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W+1 | Byte address |
| wdata_i | input | 16 | Write data (bits 7:0 in 8-bit mode) |
| be_i | input | 2 | Lane mask for 16-bit mode |
| byte_mode_i | input | 1 | 1 = 8-bit access |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read data, valid with ready_o |
| cs1_no | output | 1 | Chip select, active low |
| cs2_o | output | 1 | Chip select, active high |
| we_no | output | 1 | Write strobe, active low |
| oe_no | output | 1 | Output enable, active low |
| lb_no | output | 1 | Lower lane enable, active low |
| ub_no | output | 1 | Upper lane enable, active low |
| byte_no | output | 1 | Width select, low = 8-bit |
| mem_addr_o | output | ADDR_W | Word address to memory |
| dq_o | output | 16 | Data bus drive value |
| dq_oe_o | output | 16 | Per-bit data bus drive enable |
| dq_i | input | 16 | Data bus sampled value |

## Verification
The accept edge is the first rising edge after the bench raises req_i on a falling edge. From there, ready_o is due at edge 6 for a write and edge 5 for a read, and 10 edges later when the width mode changes, because SETTLE is 5 cycles with the bench's T_MODE_NS. The bench counts rising edges from the request and samples every output at the falling edge that follows. It checks the latency count, the write-strobe low count and the lane enables on the same cycle boundaries. One more falling-edge sample after ready_o covers the one-cycle pulse and the deselected turnaround cycle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MODE_REC,
    ST_MODE_SU,
    ST_ADDR,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC,
    ST_RTURN
  } sram_state_e;

  // ceil(ns / clk_ns), never below one cycle
  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_timer.sv
module sram_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map (
  input  logic        byte_mode_i,
  input  logic [1:0]  be_i,
  input  logic        addr_lsb_i,
  input  logic [15:0] wdata_i,
  input  logic [15:0] dq_i,
  output logic [1:0]  lane_en_o,
  output logic [15:0] dq_o,
  output logic [15:0] wr_mask_o,
  output logic [15:0] addr_mask_o,
  output logic [15:0] rdata_o
);

  logic [15:0] rd_word;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign rd_word[g*8 +: 8] = be_i[g] ? dq_i[g*8 +: 8] : 8'h00;
  end

  always_comb begin
    if (byte_mode_i) begin
      lane_en_o   = 2'b11;
      dq_o        = {addr_lsb_i, 7'b0, wdata_i[7:0]};
      wr_mask_o   = 16'h80FF;
      addr_mask_o = 16'h8000;
      rdata_o     = {8'h00, dq_i[7:0]};
    end else begin
      lane_en_o   = be_i;
      dq_o        = wdata_i;
      wr_mask_o   = 16'hFFFF;
      addr_mask_o = 16'h0000;
      rdata_o     = rd_word;
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 19,
  parameter int unsigned CLK_NS     = 20,
  parameter int unsigned T_CYCLE_NS = 70,
  parameter int unsigned T_WP_NS    = 55,
  parameter int unsigned T_AW_NS    = 65,
  parameter int unsigned T_DSU_NS   = 35,
  parameter int unsigned T_AA_NS    = 70,
  parameter int unsigned T_OE_NS    = 35,
  parameter int unsigned T_HZ_NS    = 25,
  parameter int unsigned T_MODE_NS  = 5_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W:0]   addr_i,
  input  logic [15:0]       wdata_i,
  input  logic [1:0]        be_i,
  input  logic              byte_mode_i,
  output logic              ready_o,
  output logic [15:0]       rdata_o,
  output logic              cs1_no,
  output logic              cs2_o,
  output logic              we_no,
  output logic              oe_no,
  output logic              lb_no,
  output logic              ub_no,
  output logic              byte_no,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [15:0]       dq_o,
  output logic [15:0]       dq_oe_o,
  input  logic [15:0]       dq_i
);

  localparam int unsigned CYC_MIN  = ns2cyc(T_CYCLE_NS, CLK_NS);
  localparam int unsigned WP_CYC   = umax(umax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DSU_NS, CLK_NS)),
                                          ns2cyc(T_AW_NS, CLK_NS) - 1);
  // address phase + pulse + hold must cover the minimum cycle
  localparam int unsigned HOLD_CYC = (CYC_MIN > WP_CYC + 2) ? CYC_MIN - 1 - WP_CYC : 1;
  localparam int unsigned RD_CYC   = umax(umax(ns2cyc(T_AA_NS, CLK_NS) - 1, ns2cyc(T_OE_NS, CLK_NS)), 1);
  localparam int unsigned TURN_CYC = ns2cyc(T_HZ_NS, CLK_NS);
  localparam int unsigned SET_CYC  = ns2cyc(T_MODE_NS, CLK_NS);
  localparam int unsigned MAX_CYC  = umax(umax(umax(WP_CYC, HOLD_CYC), umax(RD_CYC, TURN_CYC)), SET_CYC);
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  sram_state_e      state_q, state_d;
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  logic             latch, mode_tgl, rdy_d, cap;

  logic              we_q, bmode_q;
  logic [ADDR_W:0]   addr_q;
  logic [15:0]       wdata_q;
  logic [1:0]        be_q;
  logic              byte_no_q, ready_q;
  logic [15:0]       rdata_q;

  logic [1:0]  lane_en;
  logic [15:0] lane_dq, wr_mask, addr_mask, lane_rdata;
  logic        active, wr_drive;

  sram_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  sram_lane_map u_lane (
    .byte_mode_i (!byte_no_q),
    .be_i        (be_q),
    .addr_lsb_i  (addr_q[0]),
    .wdata_i     (wdata_q),
    .dq_i        (dq_i),
    .lane_en_o   (lane_en),
    .dq_o        (lane_dq),
    .wr_mask_o   (wr_mask),
    .addr_mask_o (addr_mask),
    .rdata_o     (lane_rdata)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    latch    = 1'b0;
    mode_tgl = 1'b0;
    rdy_d    = 1'b0;
    cap      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i && !ready_q) begin
        latch = 1'b1;
        // byte_no_q high means 16-bit mode, so equality is a mismatch
        if (byte_mode_i == byte_no_q) begin
          state_d  = ST_MODE_REC;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(SET_CYC - 1);
        end else begin
          state_d = ST_ADDR;
        end
      end
      ST_MODE_REC: if (tmr_done) begin
        mode_tgl = 1'b1;
        state_d  = ST_MODE_SU;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(SET_CYC - 1);
      end
      ST_MODE_SU: if (tmr_done) state_d = ST_ADDR;
      ST_ADDR: begin
        tmr_load = 1'b1;
        if (we_q) begin
          state_d = ST_WPULSE;
          tmr_val = CNT_W'(WP_CYC - 1);
        end else begin
          state_d = ST_RACC;
          tmr_val = CNT_W'(RD_CYC - 1);
        end
      end
      ST_WPULSE: if (tmr_done) begin
        state_d  = ST_WHOLD;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(HOLD_CYC - 1);
      end
      ST_WHOLD: if (tmr_done) begin
        state_d = ST_IDLE;
        rdy_d   = 1'b1;
      end
      ST_RACC: if (tmr_done) begin
        state_d  = ST_RTURN;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(TURN_CYC - 1);
        rdy_d    = 1'b1;
        cap      = 1'b1;
      end
      ST_RTURN: if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      we_q      <= 1'b0;
      bmode_q   <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
      byte_no_q <= 1'b1;
      ready_q   <= 1'b0;
      rdata_q   <= '0;
    end else begin
      state_q <= state_d;
      ready_q <= rdy_d;
      if (latch) begin
        we_q    <= we_i;
        bmode_q <= byte_mode_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        be_q    <= be_i;
      end
      if (mode_tgl) byte_no_q <= !bmode_q;
      if (cap)      rdata_q   <= lane_rdata;
    end
  end

  assign active   = (state_q == ST_ADDR) || (state_q == ST_WPULSE) ||
                    (state_q == ST_WHOLD) || (state_q == ST_RACC);
  assign wr_drive = (state_q == ST_WPULSE) || (state_q == ST_WHOLD);

  assign ready_o    = ready_q;
  assign rdata_o    = rdata_q;
  assign cs1_no     = !active;
  assign cs2_o      = active;
  assign we_no      = (state_q != ST_WPULSE);
  assign oe_no      = (state_q != ST_RACC);
  assign lb_no      = !(active && lane_en[0]);
  assign ub_no      = !(active && lane_en[1]);
  assign byte_no    = byte_no_q;
  assign mem_addr_o = addr_q[ADDR_W:1];
  assign dq_o       = lane_dq;
  assign dq_oe_o    = wr_drive ? wr_mask : (active ? addr_mask : 16'h0000);

  // strobe-width monitor for the pulse check
  logic [CNT_W-1:0] wp_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wp_cnt <= '0;
    else if (!we_no) wp_cnt <= wp_cnt + 1'b1;
    else             wp_cnt <= '0;
  end

  AST_WP_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_no) |-> (wp_cnt >= CNT_W'(WP_CYC))); // R2
  AST_WE_OE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> oe_no); // R2
  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o); // R4
  AST_BYTE_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byte_no && !cs1_no) |-> (!lb_no && !ub_no)); // R6
  AST_WIDTH_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_no != $past(byte_no)) |-> (cs1_no && $past(cs1_no))); // R7
  AST_NO_BUS_FIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe_o[7:0] != 8'h00) |-> oe_no); // R8
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs1_no && $past(!cs1_no)) |-> $stable(mem_addr_o)); // R9

endmodule

// File: tb/tb_sram_ctrl.sv
module tb_sram_ctrl;

  localparam int unsigned AW = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0, bmode = 1'b0;
  logic [AW:0]   addr = '0;
  logic [15:0]   wdata = '0;
  logic [1:0]    be = 2'b11;
  logic          ready_o, cs1_no, cs2_o, we_no, oe_no, lb_no, ub_no, byte_no;
  logic [15:0]   rdata_o, dq_o, dq_oe_o, dq_i, mem_rd;
  logic [AW-1:0] mem_addr_o;
  logic [15:0]   mem [0:63];

  int n_chk = 0, n_fail = 0, width_bad = 0, fight = 0;

  always #10 clk = ~clk;

  sram_ctrl #(.ADDR_W(AW), .CLK_NS(20), .T_MODE_NS(100)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .byte_mode_i(bmode), .ready_o(ready_o),
    .rdata_o(rdata_o), .cs1_no(cs1_no), .cs2_o(cs2_o), .we_no(we_no),
    .oe_no(oe_no), .lb_no(lb_no), .ub_no(ub_no), .byte_no(byte_no),
    .mem_addr_o(mem_addr_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o), .dq_i(dq_i)
  );

  // memory model
  always_comb begin
    logic [15:0] w;
    w = mem[mem_addr_o[5:0]];
    mem_rd = '0;
    if (!cs1_no && cs2_o && we_no && !oe_no) begin
      if (byte_no) mem_rd = {ub_no ? 8'h00 : w[15:8], lb_no ? 8'h00 : w[7:0]};
      else         mem_rd = {8'h00, dq_o[15] ? w[15:8] : w[7:0]};
    end
    dq_i = (dq_o & dq_oe_o) | (mem_rd & ~dq_oe_o);
  end

  always @(negedge clk) begin
    if (!cs1_no && cs2_o && !we_no) begin
      if (byte_no) begin
        if (!lb_no) mem[mem_addr_o[5:0]][7:0]  <= dq_o[7:0];
        if (!ub_no) mem[mem_addr_o[5:0]][15:8] <= dq_o[15:8];
      end else if (dq_o[15]) mem[mem_addr_o[5:0]][15:8] <= dq_o[7:0];
      else                   mem[mem_addr_o[5:0]][7:0]  <= dq_o[7:0];
    end
  end

  logic byte_no_prev = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_no !== byte_no_prev && !cs1_no) width_bad++;
      if (!oe_no && dq_oe_o[7:0] != 8'h00) fight++;
    end
    byte_no_prev <= byte_no;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  int          lat, wlo, oe_bad;
  logic [1:0]  lanes;
  logic        a15;
  logic [15:0] rd;
  logic        post_cs, post_rdy, post_oe;

  task automatic run_access(input logic w, input logic [AW:0] a, input logic [15:0] d,
                            input logic [1:0] m, input logic bm, input logic hold);
    repeat (3) @(negedge clk);
    we = w; addr = a; wdata = d; be = m; bmode = bm; req = 1'b1;
    lat = 0; wlo = 0; oe_bad = 0; lanes = 2'b11; a15 = 1'b0;
    forever begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (!we_no) begin wlo++; if (!oe_no) oe_bad++; end
      if (!cs1_no) begin lanes = {ub_no, lb_no}; a15 = dq_oe_o[15] & dq_o[15]; end
      if (ready_o || lat > 200) break;
    end
    rd = rdata_o;
    if (!hold) req = 1'b0;
    @(negedge clk);
    post_cs = cs1_no; post_rdy = ready_o; post_oe = oe_no;
    req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cs1_no", cs1_no, 1); chk("R1 cs2", cs2_o, 0);
    chk("R1 we_no", we_no, 1);   chk("R1 oe_no", oe_no, 1);
    chk("R1 lanes", {ub_no, lb_no}, 2'b11); chk("R1 byte_no", byte_no, 1);
    chk("R1 ready", ready_o, 0); chk("R1 dq_oe", dq_oe_o, 0);
  endtask

  task automatic t_word_rw();
    run_access(1, 20'd8, 16'hA5C3, 2'b11, 0, 0);
    chk("R2 write latency", lat, 6);
    chk("R2 strobe cycles", wlo, 3);
    chk("R2 oe high in write", oe_bad, 0);
    chk("R5 lanes full", lanes, 2'b00);
    run_access(0, 20'd8, 16'h0, 2'b11, 0, 0);
    chk("R3 read latency", lat, 5);
    chk("R3 read data", rd, 16'hA5C3);
    chk("R8 turnaround cs", post_cs, 1);
    chk("R8 turnaround oe", post_oe, 1);
  endtask

  task automatic t_lane_mask();
    run_access(1, 20'd8, 16'h1122, 2'b01, 0, 1);
    chk("R5 lanes lower", lanes, 2'b10);
    chk("R4 ready one cycle", post_rdy, 0);
    chk("R4 held req ignored", post_cs, 1);
    run_access(0, 20'd8, 16'h0, 2'b11, 0, 0);
    chk("R5 masked lane kept", rd, 16'hA522);
    run_access(0, 20'd8, 16'h0, 2'b10, 0, 0);
    chk("R5 disabled lane zero", rd, 16'hA500);
  endtask

  task automatic t_byte_mode();
    run_access(1, 20'd9, 16'h0077, 2'b00, 1, 0);
    chk("R7 mode switch latency", lat, 16);
    chk("R7 byte_no low", byte_no, 0);
    chk("R6 both lanes", lanes, 2'b00);
    chk("R6 lsb on bit15", a15, 1);
    run_access(0, 20'd8, 16'h0, 2'b00, 1, 0);
    chk("R6 byte read latency", lat, 5);
    chk("R6 byte read low", rd, 16'h0022);
    run_access(0, 20'd9, 16'h0, 2'b00, 1, 0);
    chk("R6 byte read high", rd, 16'h0077);
    run_access(0, 20'd8, 16'h0, 2'b11, 0, 0);
    chk("R7 switch back latency", lat, 15);
    chk("R7 word after bytes", rd, 16'h7722);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word_rw();
    t_lane_mask();
    t_byte_mode();
    chk("R7 width change deselected", width_bad, 0);
    chk("R8 no bus fight", fight, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule